// File: doc/BRIEF.md
# Nonvolatile-Array Command Sequencer

This block sits between a host register interface and a nonvolatile memory array. The host arms a command in three writes. The first is a write into the array, which captures an address and a data byte. The second is a write of a command code. The third is a write of 1 to a launch flag. The sequencer checks that the writes arrive in that order. It then runs the operation for a fixed number of ticks of a divided clock and drives program, erase or blank-read strobes to the array port while the operation lasts.

The tick clock comes from the bus clock through a programmable divider. Each tick lasts `divVal+1` bus cycles. A command runs only after the divider has been written and after any error flags have been cleared. Burst programming can overlap the next sequence with the byte in flight. A burst byte launched before the current one ends follows it with no gap, and it uses the shorter per-byte duration.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the outputs are as follows: `busy`, `done`, `accErr`, `blankErr` and all array strobes are 0, and `bufEmpty` is 1.
- R2: The sequence array write, then a command write with a known code (0x05 blank check, 0x20 byte program, 0x25 burst program, 0x40 page erase, 0x41 mass erase), then a launch write with `flagVal`=1 makes `busy` 1 and `bufEmpty` 0 in the cycle after the launch write.
- R3: A launch attempted before the divider has ever been written sets `accErr` and starts nothing.
- R4: A command keeps `busy` high for exactly N*(divVal+1) bus cycles. N is 9 for byte program, 4000 for page erase and 20000 for mass erase. When `busy` falls, `done` is 1.
- R5: `done` is cleared when a command starts, and `busy` and `done` are never both 1.
- R6: A launch-flag write with `flagVal`=0 after the array write and before the launch drops the pending sequence without an error. A later launch write then sets `accErr`.
- R7: Each of the following sets `accErr`, discards the sequence and starts nothing: an unknown command code, a command or launch write with no preceding array write, or a second array write before the launch.
- R8: While `accErr` or `blankErr` is 1, array writes are ignored, so no command can start. A pulse on `errClr` clears both flags.
- R9: During a byte program, `pgmStb` is 1, `eraseStb` is 0, `arrAddrOut` is the captured address and `arrDataOut` is the captured data.
- R10: During a page erase, `eraseStb` is 1, `massSel` is 0 and `arrAddrOut` is the captured address with its low 9 bits cleared (512-byte page). During a mass erase, `eraseStb` and `massSel` are both 1.
- R11: A blank check raises `blankRd` for 5 ticks. If `arrBlank` is 0 at its end, `blankErr` is set. If `arrBlank` is 1, `blankErr` stays 0.
- R12: A burst byte started from idle takes 9 ticks. While it runs, `bufEmpty` is 1, and a burst sequence launched no later than its final cycle runs right after it for 4 ticks. `busy` stays high throughout and `done` stays 0. A launch one cycle after `busy` falls starts a fresh 9-tick byte.
- R13: While a non-burst command runs, an array write sets `accErr`, and the running command continues with unchanged duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| divWr | input | 1 | Write strobe for the divider value |
| divVal | input | 6 | Divider value; one tick lasts divVal+1 bus cycles |
| hostArrWr | input | 1 | Host write into the array (sequence step one) |
| hostAddr | input | 16 | Array address for the array write |
| hostData | input | 8 | Data byte for the array write |
| hostCmdWr | input | 1 | Command-code write strobe (step two) |
| hostCmd | input | 8 | Command code |
| hostFlagWr | input | 1 | Write to the buffer-empty/launch flag (step three or abort) |
| flagVal | input | 1 | Value written: 1 launches, 0 aborts |
| errClr | input | 1 | Clears both error flags |
| arrBlank | input | 1 | Array reports that the checked region is erased |
| busy | output | 1 | Command in progress |
| done | output | 1 | Last command completed |
| bufEmpty | output | 1 | Command buffer can take a new sequence |
| accErr | output | 1 | Sequence or access error |
| blankErr | output | 1 | Blank check found programmed cells |
| pgmStb | output | 1 | Program strobe to the array |
| eraseStb | output | 1 | Erase strobe to the array |
| massSel | output | 1 | Erase targets the whole array |
| blankRd | output | 1 | Blank-check read strobe |
| arrAddrOut | output | 16 | Address to the array (page-aligned during page erase) |
| arrDataOut | output | 8 | Data to the array |

## Verification
The clash that matters is between finishing the current burst byte and accepting the host's launch of the next one. Both can land on the same edge. The bench times a queued burst launch so that the host write is sampled on the exact edge where the current byte's last tick expires. It judges the result by total `busy` length (9+4 ticks, continuous) and by `done` staying low. It repeats the launch one cycle later and expects a fresh full-length byte, which shows that the edge-case launch was chained and was not treated as a new start.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam logic [7:0] CMD_BLANK = 8'h05;
  localparam logic [7:0] CMD_BYTE  = 8'h20;
  localparam logic [7:0] CMD_BURST = 8'h25;
  localparam logic [7:0] CMD_PAGE  = 8'h40;
  localparam logic [7:0] CMD_MASS  = 8'h41;

  typedef enum logic [1:0] {SEQ_EMPTY, SEQ_ADDR, SEQ_CMD, SEQ_QUEUED} seqState_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic latchAddr;
    logic latchCmd;
    logic start;
    logic shortDur;
  } dpStrobe_t;

  function automatic logic isKnownCmd(input logic [7:0] c);
    return (c == CMD_BLANK) || (c == CMD_BYTE) || (c == CMD_BURST) ||
           (c == CMD_PAGE) || (c == CMD_MASS);
  endfunction
endpackage

// File: rtl/fcs_datapath.sv
module fcs_datapath
  import fcs_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int DIV_W        = 6,
  parameter int PAGE_BITS    = 9,
  parameter int PGM_TICKS    = 9,
  parameter int BURST_TICKS  = 4,
  parameter int PERASE_TICKS = 4000,
  parameter int MERASE_TICKS = 20000,
  parameter int BLANK_TICKS  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              running,
  input  logic              divWr,
  input  logic [DIV_W-1:0]  divVal,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostData,
  input  logic [7:0]        hostCmd,
  output logic              divReady,
  output logic              expire,
  output logic [7:0]        curCmd,
  output logic              pgmStb,
  output logic              eraseStb,
  output logic              massSel,
  output logic              blankRd,
  output logic [ADDR_W-1:0] arrAddrOut,
  output logic [DATA_W-1:0] arrDataOut
);
  localparam int MAX_A = (PGM_TICKS > BURST_TICKS) ? PGM_TICKS : BURST_TICKS;
  localparam int MAX_B = (PERASE_TICKS > MERASE_TICKS) ? PERASE_TICKS : MERASE_TICKS;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_T = (MAX_C > BLANK_TICKS) ? MAX_C : BLANK_TICKS;
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam logic [ADDR_W-1:0] PAGE_MASK = {ADDR_W{1'b1}} << PAGE_BITS;

  logic [DIV_W-1:0]  divReg;
  logic [DIV_W-1:0]  pre;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  durSel;
  logic [ADDR_W-1:0] pendAddr, curAddr;
  logic [DATA_W-1:0] pendData, curData;
  logic [7:0]        pendCmd;
  logic              tick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divReg   <= '0;
      divReady <= 1'b0;
    end else if (divWr) begin
      divReg   <= divVal;
      divReady <= 1'b1;
    end
  end

  // Host-side capture slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendAddr <= '0;
      pendData <= '0;
      pendCmd  <= '0;
    end else begin
      if (strb.latchAddr) begin
        pendAddr <= hostAddr;
        pendData <= hostData;
      end
      if (strb.latchCmd) pendCmd <= hostCmd;
    end
  end

  // Active slot, loaded at start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      curData <= '0;
      curCmd  <= '0;
    end else if (strb.start) begin
      curAddr <= pendAddr;
      curData <= pendData;
      curCmd  <= pendCmd;
    end
  end

  always_comb begin
    if (strb.shortDur) durSel = CNT_W'(BURST_TICKS);
    else begin
      case (pendCmd)
        CMD_BLANK: durSel = CNT_W'(BLANK_TICKS);
        CMD_PAGE:  durSel = CNT_W'(PERASE_TICKS);
        CMD_MASS:  durSel = CNT_W'(MERASE_TICKS);
        default:   durSel = CNT_W'(PGM_TICKS);
      endcase
    end
  end

  // Tick prescaler, restarted with each command
  always_ff @(posedge clk) begin
    if (!rstN) pre <= '0;
    else if (strb.start || !running || pre == divReg) pre <= '0;
    else pre <= pre + 1'b1;
  end

  assign tick   = running && (pre == divReg);
  assign expire = tick && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else if (strb.start) cnt <= durSel;
    else if (tick) cnt <= cnt - 1'b1;
  end

  assign pgmStb     = running && ((curCmd == CMD_BYTE) || (curCmd == CMD_BURST));
  assign eraseStb   = running && ((curCmd == CMD_PAGE) || (curCmd == CMD_MASS));
  assign massSel    = running && (curCmd == CMD_MASS);
  assign blankRd    = running && (curCmd == CMD_BLANK);
  assign arrAddrOut = (curCmd == CMD_PAGE) ? (curAddr & PAGE_MASK) : curAddr;
  assign arrDataOut = curData;

  a_r4_count_live: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (cnt != '0));
  a_r4_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    (running && !tick && !strb.start) |=> $stable(cnt));
  a_r12_short_only_chained: assert property (@(posedge clk) disable iff (!rstN)
    (strb.start && strb.shortDur) |-> running);
endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostArrWr,
  input  logic       hostCmdWr,
  input  logic [7:0] hostCmd,
  input  logic       hostFlagWr,
  input  logic       flagVal,
  input  logic       errClr,
  input  logic       arrBlank,
  input  logic       divReady,
  input  logic       expire,
  input  logic [7:0] curCmd,
  output dpStrobe_t  strb,
  output logic       busy,
  output logic       done,
  output logic       accErr,
  output logic       blankErr,
  output logic       bufEmpty
);
  seqState_t seq, seqNext;
  logic setAcc, canTake, errAny, launchOk, finish, chain, endNow;

  assign canTake  = !busy || (curCmd == CMD_BURST);
  assign errAny   = accErr || blankErr;
  assign launchOk = hostFlagWr && flagVal && (seq == SEQ_CMD) && divReady;
  assign finish   = busy && expire;
  assign chain    = finish && ((seq == SEQ_QUEUED) || launchOk);
  assign endNow   = finish && !chain;
  assign bufEmpty = canTake && (seq != SEQ_QUEUED);

  always_comb begin
    seqNext = seq;
    setAcc  = 1'b0;
    strb    = '0;
    if (hostArrWr) begin
      if (seq == SEQ_QUEUED) setAcc = 1'b1;
      else if (errAny) seqNext = seq;
      else if (!canTake || seq != SEQ_EMPTY) begin
        setAcc  = 1'b1;
        seqNext = SEQ_EMPTY;
      end else begin
        strb.latchAddr = 1'b1;
        seqNext = SEQ_ADDR;
      end
    end
    if (hostCmdWr) begin
      if (seq == SEQ_QUEUED) setAcc = 1'b1;
      else if (seq == SEQ_ADDR && isKnownCmd(hostCmd) && (!busy || hostCmd == CMD_BURST)) begin
        strb.latchCmd = 1'b1;
        seqNext = SEQ_CMD;
      end else begin
        setAcc  = 1'b1;
        seqNext = SEQ_EMPTY;
      end
    end
    if (hostFlagWr) begin
      if (!flagVal) begin
        if (seq == SEQ_ADDR || seq == SEQ_CMD) seqNext = SEQ_EMPTY;
      end else if (launchOk) begin
        seqNext = busy ? SEQ_QUEUED : SEQ_EMPTY;
      end else begin
        setAcc = 1'b1;
        if (seq != SEQ_QUEUED) seqNext = SEQ_EMPTY;
      end
    end
    if (!busy && launchOk) strb.start = 1'b1;
    if (chain) begin
      strb.start    = 1'b1;
      strb.shortDur = 1'b1;
      seqNext       = SEQ_EMPTY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seq      <= SEQ_EMPTY;
      busy     <= 1'b0;
      done     <= 1'b0;
      accErr   <= 1'b0;
      blankErr <= 1'b0;
    end else begin
      seq <= seqNext;
      if (strb.start) busy <= 1'b1;
      else if (finish) busy <= 1'b0;
      if (strb.start) done <= 1'b0;
      else if (endNow) done <= 1'b1;
      if (setAcc) accErr <= 1'b1;
      else if (errClr) accErr <= 1'b0;
      if (endNow && curCmd == CMD_BLANK && !arrBlank) blankErr <= 1'b1;
      else if (errClr) blankErr <= 1'b0;
    end
  end

  a_r5_busy_not_done: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);
  a_r4_done_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  a_r6_abort_stays_idle: assert property (@(posedge clk) disable iff (!rstN)
    (hostFlagWr && !flagVal && !busy) |=> !busy);
  a_r3_run_needs_divider: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> divReady);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int DIV_W        = 6,
  parameter int PAGE_BITS    = 9,
  parameter int PGM_TICKS    = 9,
  parameter int BURST_TICKS  = 4,
  parameter int PERASE_TICKS = 4000,
  parameter int MERASE_TICKS = 20000,
  parameter int BLANK_TICKS  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              divWr,
  input  logic [DIV_W-1:0]  divVal,
  input  logic              hostArrWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostData,
  input  logic              hostCmdWr,
  input  logic [7:0]        hostCmd,
  input  logic              hostFlagWr,
  input  logic              flagVal,
  input  logic              errClr,
  input  logic              arrBlank,
  output logic              busy,
  output logic              done,
  output logic              bufEmpty,
  output logic              accErr,
  output logic              blankErr,
  output logic              pgmStb,
  output logic              eraseStb,
  output logic              massSel,
  output logic              blankRd,
  output logic [ADDR_W-1:0] arrAddrOut,
  output logic [DATA_W-1:0] arrDataOut
);
  dpStrobe_t  strb;
  logic       divReady, expire;
  logic [7:0] curCmd;

  fcs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostArrWr(hostArrWr), .hostCmdWr(hostCmdWr),
    .hostCmd(hostCmd), .hostFlagWr(hostFlagWr), .flagVal(flagVal), .errClr(errClr),
    .arrBlank(arrBlank), .divReady(divReady), .expire(expire), .curCmd(curCmd),
    .strb(strb), .busy(busy), .done(done), .accErr(accErr), .blankErr(blankErr),
    .bufEmpty(bufEmpty)
  );

  fcs_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .PAGE_BITS(PAGE_BITS),
    .PGM_TICKS(PGM_TICKS), .BURST_TICKS(BURST_TICKS), .PERASE_TICKS(PERASE_TICKS),
    .MERASE_TICKS(MERASE_TICKS), .BLANK_TICKS(BLANK_TICKS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .running(busy), .divWr(divWr),
    .divVal(divVal), .hostAddr(hostAddr), .hostData(hostData), .hostCmd(hostCmd),
    .divReady(divReady), .expire(expire), .curCmd(curCmd), .pgmStb(pgmStb),
    .eraseStb(eraseStb), .massSel(massSel), .blankRd(blankRd),
    .arrAddrOut(arrAddrOut), .arrDataOut(arrDataOut)
  );
endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic divWr = 0, hostArrWr = 0, hostCmdWr = 0, hostFlagWr = 0, flagVal = 0, errClr = 0;
  logic arrBlank = 1;
  logic [5:0] divVal = '0;
  logic [15:0] hostAddr = '0;
  logic [7:0] hostData = '0, hostCmd = '0;
  logic busy, done, bufEmpty, accErr, blankErr, pgmStb, eraseStb, massSel, blankRd;
  logic [15:0] arrAddrOut;
  logic [7:0] arrDataOut;
  int cyc = 0, errors = 0, checks = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_cmd_seq u_flash_cmd_seq (
    .clk(clk), .rstN(rstN), .divWr(divWr), .divVal(divVal), .hostArrWr(hostArrWr),
    .hostAddr(hostAddr), .hostData(hostData), .hostCmdWr(hostCmdWr), .hostCmd(hostCmd),
    .hostFlagWr(hostFlagWr), .flagVal(flagVal), .errClr(errClr), .arrBlank(arrBlank),
    .busy(busy), .done(done), .bufEmpty(bufEmpty), .accErr(accErr), .blankErr(blankErr),
    .pgmStb(pgmStb), .eraseStb(eraseStb), .massSel(massSel), .blankRd(blankRd),
    .arrAddrOut(arrAddrOut), .arrDataOut(arrDataOut)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // All host tasks start and end at a falling edge
  task automatic arrWr(input logic [15:0] a, input logic [7:0] d);
    hostArrWr = 1; hostAddr = a; hostData = d; @(negedge clk); hostArrWr = 0;
  endtask
  task automatic cmdWr(input logic [7:0] c);
    hostCmdWr = 1; hostCmd = c; @(negedge clk); hostCmdWr = 0;
  endtask
  task automatic flagWr(input logic v);
    hostFlagWr = 1; flagVal = v; @(negedge clk); hostFlagWr = 0;
  endtask
  task automatic setDiv(input logic [5:0] v);
    divWr = 1; divVal = v; @(negedge clk); divWr = 0;
  endtask
  task automatic clearErr();
    errClr = 1; @(negedge clk); errClr = 0;
  endtask
  task automatic launch(input logic [15:0] a, input logic [7:0] d, input logic [7:0] c);
    arrWr(a, d); cmdWr(c); flagWr(1);
  endtask
  task automatic runLen(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask
  task automatic waitCyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic testReset();
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 bufEmpty", bufEmpty, 1);
    chk("R1 accErr", accErr, 0); chk("R1 blankErr", blankErr, 0);
    chk("R1 strobes", {pgmStb, eraseStb, blankRd, massSel}, 0);
  endtask

  task automatic testNoDivider();
    launch(16'h0010, 8'h11, 8'h20);
    chk("R3 accErr", accErr, 1); chk("R3 busy", busy, 0);
    clearErr(); chk("R8 clear acc", accErr, 0);
  endtask

  task automatic testByte(input logic [5:0] d);
    int n;
    setDiv(d);
    launch(16'h0123, 8'h5A, 8'h20);
    chk("R2 busy", busy, 1); chk("R2 bufEmpty", bufEmpty, 0); chk("R5 done clr", done, 0);
    chk("R9 pgmStb", pgmStb, 1); chk("R9 eraseStb", eraseStb, 0);
    chk("R9 addr", arrAddrOut, 16'h0123); chk("R9 data", arrDataOut, 8'h5A);
    runLen(n);
    chk("R4 byte len", n, 9 * (d + 1)); chk("R4 done", done, 1);
  endtask

  task automatic testErase();
    int n;
    launch(16'h1A37, 8'hFF, 8'h40);
    chk("R10 eraseStb", eraseStb, 1); chk("R10 massSel", massSel, 0);
    chk("R10 page addr", arrAddrOut, 16'h1A00);
    runLen(n); chk("R4 page len", n, 8000);
    launch(16'h2222, 8'h00, 8'h41);
    chk("R10 mass erase", {eraseStb, massSel}, 2'b11);
    runLen(n); chk("R4 mass len", n, 40000); chk("R4 mass done", done, 1);
  endtask

  task automatic testBlank();
    int n;
    arrBlank = 1;
    launch(16'h0400, 8'h77, 8'h05);
    chk("R11 blankRd", blankRd, 1);
    runLen(n); chk("R11 len", n, 10); chk("R11 clean", blankErr, 0);
    arrBlank = 0;
    launch(16'h0400, 8'h77, 8'h05);
    runLen(n); chk("R11 dirty", blankErr, 1);
    arrBlank = 1;
  endtask

  task automatic testErrGate();
    launch(16'h0050, 8'h01, 8'h20);
    chk("R8 gated busy", busy, 0); chk("R8 acc set", accErr, 1);
    clearErr();
    chk("R8 both clear", {accErr, blankErr}, 0);
  endtask

  task automatic testAbort();
    arrWr(16'h0060, 8'h02); cmdWr(8'h20); flagWr(0);
    chk("R6 no err", accErr, 0); chk("R6 idle", busy, 0);
    flagWr(1);
    chk("R6 stale launch", accErr, 1); chk("R6 no run", busy, 0);
    clearErr();
  endtask

  task automatic testOrder();
    arrWr(16'h0070, 8'h03); cmdWr(8'h30); chk("R7 bad code", accErr, 1);
    flagWr(1); chk("R7 bad code run", busy, 0); clearErr();
    flagWr(1); chk("R7 bare launch", accErr, 1); clearErr();
    cmdWr(8'h20); chk("R7 bare cmd", accErr, 1); clearErr();
    arrWr(16'h0070, 8'h03); arrWr(16'h0071, 8'h04); chk("R7 double write", accErr, 1);
    clearErr(); cmdWr(8'h20); flagWr(1); chk("R7 discarded", busy, 0); clearErr();
  endtask

  task automatic testBusyWrite();
    int t0;
    launch(16'h0080, 8'h05, 8'h20); t0 = cyc;
    arrWr(16'h0090, 8'h06);
    chk("R13 acc", accErr, 1); chk("R13 still pgm", pgmStb, 1);
    chk("R13 addr kept", arrAddrOut, 16'h0080);
    while (busy) @(negedge clk);
    chk("R13 len", cyc - t0, 18);
    clearErr();
  endtask

  // off: launch of the queued byte relative to the final cycle (0 = normal queue)
  task automatic testBurst(input int mode);
    int t0, n;
    launch(16'h0100, 8'hA1, 8'h25); t0 = cyc;
    chk("R12 bufEmpty in burst", bufEmpty, 1);
    arrWr(16'h0101, 8'hA2); cmdWr(8'h25);
    if (mode == 0) begin
      flagWr(1); chk("R12 queued", bufEmpty, 0);
    end else if (mode == 1) begin
      waitCyc(t0 + 17); flagWr(1);
    end else begin
      waitCyc(t0 + 18);
      chk("R12 gap busy", busy, 0); chk("R12 gap done", done, 1);
      flagWr(1); runLen(n);
      chk("R12 late full len", n, 18);
      return;
    end
    waitCyc(t0 + 18);
    chk("R12 no gap", busy, 1); chk("R12 done low", done, 0);
    chk("R12 next addr", arrAddrOut, 16'h0101);
    while (busy) @(negedge clk);
    chk("R12 chained len", cyc - t0, 26);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testNoDivider();
    testByte(6'd0); testByte(6'd3); testByte(6'd1);
    testErase();
    testBlank();
    testErrGate();
    testAbort();
    testOrder();
    testBusyWrite();
    testBurst(0); testBurst(1); testBurst(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule